// File: doc/BRIEF.md
# Wordline Charge-Recycling Sequencer

This block generates the control phases that a reservoir-assisted wordline driver needs for each row access. A request carries a row index. The block opens the selected wordline by tying it to a large reservoir capacitor, which lifts it part of the way. It then releases that tie and drives the line to the full supply. Next it reconnects the line to the reservoir so that the borrowed charge flows back. Finally it pulls the line to ground while the reservoir floats. An access therefore carries two separate share pulses, one before and one after the full-level drive, and ends with a discharge. The analogue devices and voltages lie outside the block. It produces only the strobes, the wordline-enable, the row index and a one-hot row select.

Requests arrive on a valid/ready interface. In idle, an accepted request starts its sequence on the next cycle. A request that arrives while a sequence runs goes into a single hold slot. It launches right after the running sequence's discharge phase, with no idle cycle between the two. While the slot is full, `req_ready` is low and the requester must keep its request until `req_ready` returns high. The reservoir reaches its working voltage on its own after a number of accesses, so no reference generator is needed. A saturating access counter raises `settled` once `SETTLE_COUNT` sequences (10 by default) have completed since reset.

Top module: `wl_recycle_seq`

## Requirements
- R1: During and after reset, `wl_en`, `share_stb`, `drive_stb`, `disch_stb`, `row_idx` and `wl_sel` are all 0, `settled` is 0 and `req_ready` is 1.
- R2: When a request is accepted in idle (`req_valid` and `req_ready` high at a rising edge), `wl_en` is high from the next cycle on for exactly 2·SHARE_CYC + 2·GAP_CYC + DRIVE_CYC + DISCH_CYC cycles. In that window the phases run in this fixed order: share for SHARE_CYC cycles, neither strobe for GAP_CYC, drive for DRIVE_CYC, neither strobe for GAP_CYC, share for SHARE_CYC, discharge for DISCH_CYC. The block then returns to idle unless a launch is due.
- R3: At most one of `share_stb`, `drive_stb` and `disch_stb` is high in any cycle. A share strobe and a drive strobe are never high in adjacent cycles (GAP_CYC must be at least 1).
- R4: Throughout a sequence, `row_idx` equals the accepted row and `wl_sel` is one-hot with bit `row_idx` set. Both are 0 while `wl_en` is low.
- R5: `req_ready` is low exactly while a held request waits. A request accepted during a sequence is held, and its first share cycle follows directly after the last discharge cycle of the running sequence.
- R6: A request accepted at the edge that ends the last discharge cycle, while the hold slot is empty, starts its share phase in the next cycle with no idle cycle.
- R7: `settled` rises in the cycle after the SETTLE_COUNT-th completed discharge since reset, and it stays high until reset.
- R8: A request offered while `req_ready` is low is not taken. It never produces a sequence of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Row-access request offered |
| req_ready | output | 1 | Request can be taken this cycle |
| req_row | input | ROW_W | Row index of the offered request |
| wl_en | output | 1 | Wordline enable, high for the whole sequence |
| share_stb | output | 1 | Connect selected wordline to the reservoir |
| drive_stb | output | 1 | Pull selected wordline to the supply |
| disch_stb | output | 1 | Pull selected wordline to ground, reservoir floating |
| row_idx | output | ROW_W | Row of the running sequence, 0 in idle |
| wl_sel | output | ROWS | One-hot select of the running row, 0 in idle |
| settled | output | 1 | Reservoir considered settled |

## Verification
The bench runs one isolated access on every row index. It checks every cycle of each window against a phase table that it computes from the four phase lengths. This separates phase-length and ordering faults from row-decode faults, and the same run carries the completion count across the settle threshold. A back-to-back pattern offers a second request mid-sequence and then a third while the slot is full. It tells whether the held row launches with no gap and whether a refused request leaks through. A request placed exactly in the last discharge cycle, and a reset asserted in the middle of a sequence, cover the seamless-restart boundary and the clearing of the settle state.

// File: rtl/wlr_pkg.sv
package wlr_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SHARE1 = 3'd1,
    PH_GAP1   = 3'd2,
    PH_DRIVE  = 3'd3,
    PH_GAP2   = 3'd4,
    PH_SHARE2 = 3'd5,
    PH_DISCH  = 3'd6
  } wlr_phase_e;
endpackage

// File: rtl/wlr_phase_fsm.sv
module wlr_phase_fsm #(
  parameter int SHARE_CYC = 1,
  parameter int GAP_CYC   = 1,
  parameter int DRIVE_CYC = 1,
  parameter int DISCH_CYC = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                launch_i,
  output wlr_pkg::wlr_phase_e phase_o,
  output logic                take_o,
  output logic                seq_end_o
);
  import wlr_pkg::*;

  localparam int MAX_AB  = (SHARE_CYC > GAP_CYC) ? SHARE_CYC : GAP_CYC;
  localparam int MAX_CD  = (DRIVE_CYC > DISCH_CYC) ? DRIVE_CYC : DISCH_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  wlr_phase_e        phase_q, phase_d;
  logic [TMR_W-1:0]  tmr_q;
  logic              last;

  function automatic logic [TMR_W-1:0] len_m1(wlr_phase_e p);
    case (p)
      PH_SHARE1, PH_SHARE2: len_m1 = TMR_W'(SHARE_CYC - 1);
      PH_GAP1, PH_GAP2:     len_m1 = TMR_W'(GAP_CYC - 1);
      PH_DRIVE:             len_m1 = TMR_W'(DRIVE_CYC - 1);
      PH_DISCH:             len_m1 = TMR_W'(DISCH_CYC - 1);
      default:              len_m1 = '0;
    endcase
  endfunction

  assign last = (tmr_q == '0);

  always_comb begin
    phase_d = phase_q;
    case (phase_q)
      PH_IDLE:   if (launch_i) phase_d = PH_SHARE1;
      PH_SHARE1: if (last) phase_d = PH_GAP1;
      PH_GAP1:   if (last) phase_d = PH_DRIVE;
      PH_DRIVE:  if (last) phase_d = PH_GAP2;
      PH_GAP2:   if (last) phase_d = PH_SHARE2;
      PH_SHARE2: if (last) phase_d = PH_DISCH;
      PH_DISCH:  if (last) phase_d = launch_i ? PH_SHARE1 : PH_IDLE;
      default:   phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      tmr_q   <= '0;
    end else begin
      phase_q <= phase_d;
      if (phase_d != phase_q)
        tmr_q <= len_m1(phase_d);
      else if (!last)
        tmr_q <= tmr_q - 1'b1;
    end
  end

  assign phase_o   = phase_q;
  assign seq_end_o = (phase_q == PH_DISCH) && last;
  assign take_o    = (phase_q == PH_IDLE) || seq_end_o;

  // R2: leaving discharge only ever goes to idle or a fresh first share
  a_r2_disch_exit: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) == PH_DISCH && phase_q != PH_DISCH)
      |-> (phase_q == PH_IDLE || phase_q == PH_SHARE1));

  // R2: the return share is always entered from the second gap
  a_r2_share2_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(phase_q) != PH_SHARE2 && phase_q == PH_SHARE2) |-> $past(phase_q) == PH_GAP2);
endmodule

// File: rtl/wlr_req_hold.sv
module wlr_req_hold #(
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_i,
  input  logic             take_i,
  input  logic [ROW_W-1:0] req_row_i,
  output logic             pend_valid_o,
  output logic [ROW_W-1:0] pend_row_o
);
  logic             pend_valid_q;
  logic [ROW_W-1:0] pend_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_valid_q <= 1'b0;
      pend_row_q   <= '0;
    end else if (take_i && pend_valid_q) begin
      pend_valid_q <= 1'b0;
    end else if (acc_i && !take_i) begin
      pend_valid_q <= 1'b1;
      pend_row_q   <= req_row_i;
    end
  end

  assign pend_valid_o = pend_valid_q;
  assign pend_row_o   = pend_row_q;

  // R5: a waiting request keeps its row until it is launched
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_valid_q && !take_i) |=> (pend_valid_q && $stable(pend_row_q)));

  // R8: nothing is accepted on top of a waiting request
  a_r8_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_q |-> !acc_i);
endmodule

// File: rtl/wlr_settle_cnt.sv
module wlr_settle_cnt #(
  parameter int SETTLE_COUNT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic seq_end_i,
  output logic settled_o
);
  localparam int CNT_W = $clog2(SETTLE_COUNT + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             full;

  assign full = (cnt_q == CNT_W'(SETTLE_COUNT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (seq_end_i && !full)
      cnt_q <= cnt_q + 1'b1;
  end

  assign settled_o = full;

  // R7: once settled, stays settled until reset
  a_r7_settled_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    settled_o |=> settled_o);

  // R7: the count moves only on a completed access
  a_r7_count_steps: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_end_i |=> $stable(cnt_q));
endmodule

// File: rtl/wl_recycle_seq.sv
module wl_recycle_seq #(
  parameter int ROWS         = 16,
  parameter int SETTLE_COUNT = 10,
  parameter int SHARE_CYC    = 1,
  parameter int GAP_CYC      = 1,
  parameter int DRIVE_CYC    = 1,
  parameter int DISCH_CYC    = 1,
  localparam int ROW_W       = $clog2(ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [ROW_W-1:0] req_row,
  output logic             wl_en,
  output logic             share_stb,
  output logic             drive_stb,
  output logic             disch_stb,
  output logic [ROW_W-1:0] row_idx,
  output logic [ROWS-1:0]  wl_sel,
  output logic             settled
);
  import wlr_pkg::*;

  wlr_phase_e       phase;
  logic             take, seq_end, acc, launch;
  logic             pend_valid;
  logic [ROW_W-1:0] pend_row;
  logic [ROW_W-1:0] cur_row_q;

  assign req_ready = !pend_valid;
  assign acc       = req_valid && req_ready;
  assign launch    = pend_valid || acc;

  wlr_phase_fsm #(
    .SHARE_CYC(SHARE_CYC), .GAP_CYC(GAP_CYC),
    .DRIVE_CYC(DRIVE_CYC), .DISCH_CYC(DISCH_CYC)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .launch_i(launch),
    .phase_o(phase), .take_o(take), .seq_end_o(seq_end)
  );

  wlr_req_hold #(.ROW_W(ROW_W)) hold_i (
    .clk(clk), .rst_n(rst_n), .acc_i(acc), .take_i(take),
    .req_row_i(req_row), .pend_valid_o(pend_valid), .pend_row_o(pend_row)
  );

  wlr_settle_cnt #(.SETTLE_COUNT(SETTLE_COUNT)) settle_i (
    .clk(clk), .rst_n(rst_n), .seq_end_i(seq_end), .settled_o(settled)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cur_row_q <= '0;
    else if (take && launch)
      cur_row_q <= pend_valid ? pend_row : req_row;
  end

  assign wl_en     = (phase != PH_IDLE);
  assign share_stb = (phase == PH_SHARE1) || (phase == PH_SHARE2);
  assign drive_stb = (phase == PH_DRIVE);
  assign disch_stb = (phase == PH_DISCH);
  assign row_idx   = wl_en ? cur_row_q : '0;

  for (genvar g = 0; g < ROWS; g++) begin : g_sel
    assign wl_sel[g] = wl_en && (cur_row_q == ROW_W'(g));
  end

  // R3: strobes never overlap
  a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({share_stb, drive_stb, disch_stb}));

  // R3: share and drive are always separated by a quiet cycle
  a_r3_share_drive_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (share_stb |=> !drive_stb) and (drive_stb |=> !share_stb));

  // R2: every access opens with a share
  a_r2_open_with_share: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wl_en) |-> share_stb);

  // R2: discharge follows the return share
  a_r2_disch_after_share: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disch_stb) |-> $past(share_stb));

  // R4: row stays fixed inside a sequence
  a_r4_row_held: assert property (@(posedge clk) disable iff (!rst_n)
    (wl_en && $past(wl_en) && !($past(disch_stb) && !disch_stb)) |-> $stable(row_idx));

  // R4: selection is one-hot while active
  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    wl_en |-> $countones(wl_sel) == 1);
endmodule

// File: tb/wl_recycle_seq_tb_top.sv
module wl_recycle_seq_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ROWS       = 16;
  localparam int ROW_W      = 4;
  localparam int SETTLE     = 10;
  localparam int SH         = 2;
  localparam int GP         = 1;
  localparam int DR         = 3;
  localparam int DS         = 2;
  localparam int B1 = SH, B2 = B1 + GP, B3 = B2 + DR, B4 = B3 + GP, B5 = B4 + SH;
  localparam int TOTAL = B5 + DS;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready;
  logic [ROW_W-1:0] req_row;
  logic wl_en, share_stb, drive_stb, disch_stb, settled;
  logic [ROW_W-1:0] row_idx;
  logic [ROWS-1:0] wl_sel;

  int n_checks = 0;
  int n_errors = 0;
  int done_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wl_recycle_seq #(
    .ROWS(ROWS), .SETTLE_COUNT(SETTLE),
    .SHARE_CYC(SH), .GAP_CYC(GP), .DRIVE_CYC(DR), .DISCH_CYC(DS)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .wl_en(wl_en), .share_stb(share_stb), .drive_stb(drive_stb),
    .disch_stb(disch_stb), .row_idx(row_idx), .wl_sel(wl_sel), .settled(settled)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  // {wl_en, share, drive, disch} expected at offset o of a sequence
  function automatic logic [3:0] exp_phase(int o);
    if (o < B1) return 4'b1100;
    if (o < B2) return 4'b1000;
    if (o < B3) return 4'b1010;
    if (o < B4) return 4'b1000;
    if (o < B5) return 4'b1100;
    return 4'b1001;
  endfunction

  task automatic chk_active(int o, int row);
    check("R2 R3 phase", {28'd0, wl_en, share_stb, drive_stb, disch_stb}, {28'd0, exp_phase(o)});
    check("R4 row", {12'd0, row_idx, wl_sel}, (row << 16) | (1 << row));
    check("R7 settled", {31'd0, settled}, {31'd0, done_cnt >= SETTLE});
  endtask

  task automatic chk_idle();
    check("R1 idle outputs", {11'd0, wl_en, share_stb, drive_stb, disch_stb, row_idx, wl_sel}, 32'd0);
    check("R5 ready idle", {31'd0, req_ready}, 32'd1);
    check("R7 settled", {31'd0, settled}, {31'd0, done_cnt >= SETTLE});
  endtask

  // at a negedge, offer a row; return at the negedge of offset 0
  task automatic issue(int row);
    req_valid = 1'b1;
    req_row   = ROW_W'(row);
    check("R5 ready on offer", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic run_window(int row);
    for (int o = 0; o < TOTAL; o++) begin
      chk_active(o, row);
      @(negedge clk);
    end
    done_cnt++;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_errors++;
    $display("FAIL watchdog expired got=hung exp=finished");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_row = '0;
    repeat (3) @(negedge clk);
    chk_idle();                          // R1 during reset
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle();                          // R1 after reset

    // sweep every row with isolated accesses; crosses the settle point (R7)
    for (int r = 0; r < ROWS; r++) begin
      issue(r);
      run_window(r);
      chk_idle();
    end

    // back-to-back: held request launches with no gap (R5), refused one is lost (R8)
    issue(3);
    for (int o = 0; o < TOTAL; o++) begin
      chk_active(o, 3);
      if (o == 2) begin req_valid = 1'b1; req_row = 4'd9; end
      if (o >= 3) begin
        check("R5 R8 ready low while held", {31'd0, req_ready}, 32'd0);
        req_row = 4'd12;
      end
      if (o == TOTAL - 1) req_valid = 1'b0;
      @(negedge clk);
    end
    done_cnt++;
    run_window(9);
    chk_idle();                          // R8 row 12 never started
    @(negedge clk);
    chk_idle();

    // request in the last discharge cycle starts directly (R6)
    issue(5);
    for (int o = 0; o < TOTAL; o++) begin
      chk_active(o, 5);
      if (o == TOTAL - 1) begin
        check("R6 ready in last discharge", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_row = 4'd14;
      end
      @(negedge clk);
    end
    done_cnt++;
    req_valid = 1'b0;
    run_window(14);
    chk_idle();

    // reset in mid-sequence clears everything (R1, R7)
    issue(7);
    for (int o = 0; o < 4; o++) begin
      chk_active(o, 7);
      @(negedge clk);
    end
    rst_n = 1'b0;
    done_cnt = 0;
    @(negedge clk);
    chk_idle();
    check("R7 settled cleared by reset", {31'd0, settled}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    issue(11);
    run_window(11);
    chk_idle();

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule